// File: doc/BRIEF.md
# Regulator Enable and Soft-Start Sequencer

This block is the digital sequencing core of a multiphase voltage regulator controller. It merges the supply-good, enable-comparator and logic-enable qualifiers with the 6-bit voltage identification code. It decides when the converter may leave shutdown. It then drives the reference DAC code through a fixed pre-delay and a linear ramp, and it holds the phase PWM outputs in high impedance until switching is safe.

Time in the sequencer is counted in switching periods. A one-clock `sw_tick` pulse marks each period. After start, the block waits 64 periods with the reference at zero. The reference then climbs one code step per period, where one step is 1/1280 V, until it reaches `target_code`. The PWM outputs stay tri-stated during the ramp until the analog side reports that the rising reference has caught up with any charge already on the output. Power-good is raised only once the ramp is complete and the output sits inside its regulation window.

Two VID codes mean "no load". After two switching periods they move the overvoltage trip to its shutdown level and stop the PWM. Any other code restarts soft start. An overvoltage fault latches a shutdown that only a loss of the supply-good flag releases.

States:
- `ST_OFF`: shutdown.
- `ST_PREDLY`: pre-delay.
- `ST_RAMP_HIZ`: ramp with PWM tri-stated.
- `ST_RAMP_RUN`: ramp with PWM switching.
- `ST_REGULATE`: ramp complete.
- `ST_NL_OFF`: no-load shutdown.
- `ST_OV_LATCH`: latched overvoltage.

Transitions:
- `ST_OFF`/`ST_NL_OFF` to `ST_PREDLY` when all start conditions hold.
- `ST_PREDLY` to `ST_RAMP_HIZ` on the 64th tick.
- `ST_RAMP_HIZ` to `ST_RAMP_RUN` when `ref_at_vout` is high.
- `ST_RAMP_RUN` to `ST_REGULATE` when the DAC code reaches the target.
- Any running state to `ST_NL_OFF` when the no-load delay expires.
- Any state to `ST_OFF` when an enable qualifier drops.
- Any state to `ST_OV_LATCH` on `ov_fault`.
- `ST_OV_LATCH` to `ST_OFF` only when `por_ok` falls.

Top module: `vr_softstart_seq`

## Requirements
- R1: The block leaves shutdown only when `por_ok`, `en_cmp` and `en_logic` are all 1 and `vid_code` is neither 6'b111111 nor 6'b111110. Soft start begins on the first clock edge at which all of these hold.
- R2: For the first 64 `sw_tick` pulses after start, `dac_code` is 0 and `pwm_hiz` is 1, whatever `ref_at_vout` does.
- R3: After the pre-delay, `dac_code` rises by exactly 1 on each `sw_tick` until it equals `target_code`, then holds.
- R4: `pwm_hiz` is 1 in every shutdown state. During the ramp it is 1 until `ref_at_vout` has been seen high, and it is 0 from the next clock on.
- R5: `pgood` is 1 only when the ramp has completed and `vout_in_window` is 1. It follows `vout_in_window` combinationally in that state.
- R6: After a no-load code (6'b111111 or 6'b111110) appears, outputs are unchanged through the first `sw_tick`. At most two clocks after the second `sw_tick`, `pwm_hiz` and `ov_shutdown_lvl` are 1 and `dac_code` is 0.
- R7: Replacing a no-load code with any other code, while the enable qualifiers hold, restarts soft start at the pre-delay with `ov_shutdown_lvl` 0.
- R8: A high `ov_fault` latches shutdown: `pwm_hiz` and `ov_shutdown_lvl` are 1. Neither no-load codes nor toggling the enable inputs release it. It clears only when `por_ok` goes low.
- R9: If `por_ok`, `en_cmp` or `en_logic` falls, one clock later `dac_code` is 0, `pgood` is 0 and `pwm_hiz` is 1.
- R10: During and after reset with the qualifiers low, `dac_code` is 0, `pwm_hiz` is 1, `ov_shutdown_lvl` is 1 and `pgood` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| por_ok | input | 1 | Bias supply above power-on threshold |
| en_cmp | input | 1 | Digitized enable-comparator output |
| en_logic | input | 1 | Logic-level enable line |
| vid_code | input | 6 | Voltage identification code |
| target_code | input | 12 | Target reference code, 1/1280 V per step |
| sw_tick | input | 1 | One-clock pulse per switching period |
| ref_at_vout | input | 1 | Ramping reference has reached sensed output |
| vout_in_window | input | 1 | Output within regulation window |
| ov_fault | input | 1 | Overvoltage fault detected |
| dac_code | output | 12 | Reference DAC code |
| pwm_hiz | output | 1 | Hold phase PWM outputs high impedance |
| ov_shutdown_lvl | output | 1 | Select shutdown overvoltage trip level |
| pgood | output | 1 | Power good |

## Verification
The assertions assume that `sw_tick` is a single-clock pulse, so the ramp step property may credit each code change to exactly one tick. They also assume that `target_code` stays constant while a ramp is in progress. The stimulus respects both: every tick is one clock high followed by two idle clocks, and the target is written only while the block is in shutdown. Analog flags such as `ref_at_vout` and `vout_in_window` are driven on the falling edge, and the bench holds them steady across the edges it checks.

// File: rtl/vr_seq_pkg.sv
package vr_seq_pkg;

    localparam int VID_W = 6;

    typedef enum logic [2:0] {
        ST_OFF      = 3'd0,
        ST_PREDLY   = 3'd1,
        ST_RAMP_HIZ = 3'd2,
        ST_RAMP_RUN = 3'd3,
        ST_REGULATE = 3'd4,
        ST_NL_OFF   = 3'd5,
        ST_OV_LATCH = 3'd6
    } seq_state_t;

endpackage

// File: rtl/vr_enable_qual.sv
module vr_enable_qual #(
    parameter int VID_W    = 6,
    parameter int NL_DELAY = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             por_ok,
    input  logic             en_cmp,
    input  logic             en_logic,
    input  logic [VID_W-1:0] vid_code,
    input  logic             sw_tick,
    output logic             hard_ok,
    output logic             vid_noload,
    output logic             start_ok,
    output logic             nl_shutdown
);
    localparam int CW = $clog2(NL_DELAY + 1);

    logic [CW-1:0] nl_cnt;

    // The two no-load codes share every bit but the lowest.
    always_comb begin
        hard_ok     = por_ok & en_cmp & en_logic;
        vid_noload  = &vid_code[VID_W-1:1];
        start_ok    = hard_ok & ~vid_noload;
        nl_shutdown = (nl_cnt == CW'(NL_DELAY));
    end

    // Counts switching periods while a no-load code is present; saturates.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nl_cnt <= '0;
        end else if (!vid_noload) begin
            nl_cnt <= '0;
        end else if (sw_tick && !nl_shutdown) begin
            nl_cnt <= nl_cnt + 1'b1;
        end
    end

    // R6: the no-load delay can only expire on a switching-period edge
    a_r6_nl_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nl_shutdown) |-> $past(sw_tick) && $past(vid_noload));

endmodule

// File: rtl/vr_ref_ramp.sv
module vr_ref_ramp #(
    parameter int DAC_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step_en,
    input  logic             sw_tick,
    input  logic [DAC_W-1:0] target,
    output logic [DAC_W-1:0] dac_q,
    output logic             at_target
);
    assign at_target = (dac_q >= target);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dac_q <= '0;
        end else if (clr) begin
            dac_q <= '0;
        end else if (step_en && sw_tick && !at_target) begin
            dac_q <= dac_q + 1'b1;
        end
    end

    // R3: outside a clear, the code only moves up by one on a tick
    a_r3_ramp_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(clr) && dac_q != $past(dac_q))
            |-> (dac_q == $past(dac_q) + 1'b1) && $past(sw_tick));

    // R3: the ramp never passes a steady target
    a_r3_no_overshoot: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && $stable(target) && $past(dac_q) <= $past(target))
            |-> dac_q <= target);

endmodule

// File: rtl/vr_seq_fsm.sv
module vr_seq_fsm
    import vr_seq_pkg::*;
#(
    parameter int DAC_W      = 12,
    parameter int PRE_TICKS  = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             por_ok,
    input  logic             hard_ok,
    input  logic             start_ok,
    input  logic             nl_shutdown,
    input  logic             ov_fault,
    input  logic             sw_tick,
    input  logic             ref_at_vout,
    input  logic             vout_in_window,
    input  logic             at_target,
    input  logic [DAC_W-1:0] dac_val,
    output logic             ramp_clr,
    output logic             ramp_en,
    output logic [DAC_W-1:0] dac_code,
    output logic             pwm_hiz,
    output logic             ov_shutdown_lvl,
    output logic             pgood
);
    localparam int PW = $clog2(PRE_TICKS + 1);

    seq_state_t    state_q;
    seq_state_t    state_d;
    logic [PW-1:0] pre_cnt;
    logic          pre_done;

    assign pre_done = sw_tick && (pre_cnt == PW'(PRE_TICKS - 1));

    // Pre-delay period counter, live only in the pre-delay state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt <= '0;
        end else if (state_q != ST_PREDLY) begin
            pre_cnt <= '0;
        end else if (sw_tick) begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (!por_ok) begin
            state_d = ST_OFF;
        end else if (state_q == ST_OV_LATCH || ov_fault) begin
            state_d = ST_OV_LATCH;
        end else if (!hard_ok) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF, ST_NL_OFF: begin
                    if (start_ok) state_d = ST_PREDLY;
                end
                ST_PREDLY: begin
                    if (nl_shutdown)   state_d = ST_NL_OFF;
                    else if (pre_done) state_d = ST_RAMP_HIZ;
                end
                ST_RAMP_HIZ: begin
                    if (nl_shutdown)      state_d = ST_NL_OFF;
                    else if (ref_at_vout) state_d = ST_RAMP_RUN;
                end
                ST_RAMP_RUN: begin
                    if (nl_shutdown)    state_d = ST_NL_OFF;
                    else if (at_target) state_d = ST_REGULATE;
                end
                ST_REGULATE: begin
                    if (nl_shutdown) state_d = ST_NL_OFF;
                end
                ST_OV_LATCH: state_d = ST_OV_LATCH;
                default:     state_d = ST_OFF;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Output decode
    always_comb begin
        ramp_clr        = 1'b1;
        ramp_en         = 1'b0;
        dac_code        = '0;
        pwm_hiz         = 1'b1;
        ov_shutdown_lvl = 1'b0;
        pgood           = 1'b0;
        unique case (state_q)
            ST_OFF, ST_NL_OFF, ST_OV_LATCH: begin
                ov_shutdown_lvl = 1'b1;
            end
            ST_PREDLY: begin
                ramp_clr = 1'b1;
            end
            ST_RAMP_HIZ: begin
                ramp_clr = 1'b0;
                ramp_en  = 1'b1;
                dac_code = dac_val;
            end
            ST_RAMP_RUN: begin
                ramp_clr = 1'b0;
                ramp_en  = 1'b1;
                dac_code = dac_val;
                pwm_hiz  = 1'b0;
            end
            ST_REGULATE: begin
                ramp_clr = 1'b0;
                dac_code = dac_val;
                pwm_hiz  = 1'b0;
                pgood    = vout_in_window;
            end
            default: begin
                ov_shutdown_lvl = 1'b1;
            end
        endcase
    end

    // R1: the pre-delay is entered only from a qualified start
    a_r1_start_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PREDLY && $past(state_q) != ST_PREDLY) |-> $past(start_ok));

    // R2: reference at zero and PWM tri-stated during pre-delay
    a_r2_predly_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PREDLY) |-> (dac_code == '0) && pwm_hiz);

    // R4: PWM released only after the reference reached the output
    a_r4_hiz_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwm_hiz) |-> $past(ref_at_vout));

    // R5: power-good only with the output inside the window and PWM running
    a_r5_pgood_window: assert property (@(posedge clk) disable iff (!rst_n)
        pgood |-> vout_in_window && !pwm_hiz);

    // R8: the overvoltage latch holds while supply-good stays high
    a_r8_ov_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OV_LATCH && por_ok) |=> (state_q == ST_OV_LATCH) && pwm_hiz);

    // R9: losing a qualifier clears reference and power-good one clock later
    a_r9_disable_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(hard_ok) |-> (dac_code == '0) && !pgood && pwm_hiz);

endmodule

// File: rtl/vr_softstart_seq.sv
module vr_softstart_seq
    import vr_seq_pkg::*;
#(
    parameter int DAC_W     = 12,
    parameter int PRE_TICKS = 64,
    parameter int NL_DELAY  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             por_ok,
    input  logic             en_cmp,
    input  logic             en_logic,
    input  logic [VID_W-1:0] vid_code,
    input  logic [DAC_W-1:0] target_code,
    input  logic             sw_tick,
    input  logic             ref_at_vout,
    input  logic             vout_in_window,
    input  logic             ov_fault,
    output logic [DAC_W-1:0] dac_code,
    output logic             pwm_hiz,
    output logic             ov_shutdown_lvl,
    output logic             pgood
);
    logic             hard_ok;
    logic             vid_noload;
    logic             start_ok;
    logic             nl_shutdown;
    logic             ramp_clr;
    logic             ramp_en;
    logic             at_target;
    logic [DAC_W-1:0] dac_val;

    vr_enable_qual #(
        .VID_W    (VID_W),
        .NL_DELAY (NL_DELAY)
    ) u_qual (
        .clk         (clk),
        .rst_n       (rst_n),
        .por_ok      (por_ok),
        .en_cmp      (en_cmp),
        .en_logic    (en_logic),
        .vid_code    (vid_code),
        .sw_tick     (sw_tick),
        .hard_ok     (hard_ok),
        .vid_noload  (vid_noload),
        .start_ok    (start_ok),
        .nl_shutdown (nl_shutdown)
    );

    vr_ref_ramp #(
        .DAC_W (DAC_W)
    ) u_ramp (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (ramp_clr),
        .step_en   (ramp_en),
        .sw_tick   (sw_tick),
        .target    (target_code),
        .dac_q     (dac_val),
        .at_target (at_target)
    );

    vr_seq_fsm #(
        .DAC_W     (DAC_W),
        .PRE_TICKS (PRE_TICKS)
    ) u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .por_ok          (por_ok),
        .hard_ok         (hard_ok),
        .start_ok        (start_ok),
        .nl_shutdown     (nl_shutdown),
        .ov_fault        (ov_fault),
        .sw_tick         (sw_tick),
        .ref_at_vout     (ref_at_vout),
        .vout_in_window  (vout_in_window),
        .at_target       (at_target),
        .dac_val         (dac_val),
        .ramp_clr        (ramp_clr),
        .ramp_en         (ramp_en),
        .dac_code        (dac_code),
        .pwm_hiz         (pwm_hiz),
        .ov_shutdown_lvl (ov_shutdown_lvl),
        .pgood           (pgood)
    );

    // R6: the shutdown trip level is chosen only with PWM stopped
    a_r6_level_with_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        ov_shutdown_lvl |-> pwm_hiz && (dac_code == '0));

    // R6: a no-load code held across its delay ends in shutdown
    a_r6_nl_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(nl_shutdown) && $past(hard_ok) && vid_noload) |-> ov_shutdown_lvl);

endmodule

// File: tb/test_vr_softstart_seq.sv
module test_vr_softstart_seq;

    localparam int DAC_W = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             por_ok = 1'b0;
    logic             en_cmp = 1'b0;
    logic             en_logic = 1'b0;
    logic [5:0]       vid_code = 6'h10;
    logic [DAC_W-1:0] target_code = '0;
    logic             sw_tick = 1'b0;
    logic             ref_at_vout = 1'b0;
    logic             vout_in_window = 1'b0;
    logic             ov_fault = 1'b0;
    logic [DAC_W-1:0] dac_code;
    logic             pwm_hiz;
    logic             ov_shutdown_lvl;
    logic             pgood;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    vr_softstart_seq i_vr_softstart_seq (
        .clk             (clk),
        .rst_n           (rst_n),
        .por_ok          (por_ok),
        .en_cmp          (en_cmp),
        .en_logic        (en_logic),
        .vid_code        (vid_code),
        .target_code     (target_code),
        .sw_tick         (sw_tick),
        .ref_at_vout     (ref_at_vout),
        .vout_in_window  (vout_in_window),
        .ov_fault        (ov_fault),
        .dac_code        (dac_code),
        .pwm_hiz         (pwm_hiz),
        .ov_shutdown_lvl (ov_shutdown_lvl),
        .pgood           (pgood)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clocks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) sw_tick = 1'b1;
            @(negedge clk) sw_tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic enable_all(input logic [5:0] vid);
        vid_code = vid;
        por_ok   = 1'b1;
        en_cmp   = 1'b1;
        en_logic = 1'b1;
    endtask

    // Drives a fresh start up to regulation without checks.
    task automatic go_regulate(input int tgt);
        target_code    = DAC_W'(tgt);
        ref_at_vout    = 1'b1;
        vout_in_window = 1'b1;
        enable_all(6'h10);
        clocks(1);
        ticks(64 + tgt + 1);
    endtask

    task automatic t_reset;
        chk("R10 dac", dac_code, 0);
        chk("R10 hiz", pwm_hiz, 1);
        chk("R10 ovlvl", ov_shutdown_lvl, 1);
        chk("R10 pgood", pgood, 0);
    endtask

    task automatic t_start_blocked;
        target_code = 12'd8;
        enable_all(6'h3E);
        clocks(3);
        ticks(2);
        chk("R1 noload 3E blocks start", ov_shutdown_lvl, 1);
        vid_code = 6'h3F;
        clocks(3);
        chk("R1 noload 3F blocks start", ov_shutdown_lvl, 1);
        vid_code = 6'h10;
        en_cmp = 1'b0;
        clocks(3);
        chk("R1 en_cmp low blocks start", ov_shutdown_lvl, 1);
        en_cmp = 1'b1;
        en_logic = 1'b0;
        clocks(3);
        chk("R1 en_logic low blocks start", ov_shutdown_lvl, 1);
        en_logic = 1'b1;
        clocks(1);
        chk("R1 start on all good", ov_shutdown_lvl, 0);
        chk("R2 hiz at start", pwm_hiz, 1);
        por_ok = 1'b0;
        clocks(2);
    endtask

    task automatic t_normal_start;
        target_code    = 12'd20;
        ref_at_vout    = 1'b0;
        vout_in_window = 1'b1;
        enable_all(6'h12);
        clocks(1);
        chk("R1 started", ov_shutdown_lvl, 0);
        ref_at_vout = 1'b1;
        ticks(63);
        chk("R2 dac zero in predelay", dac_code, 0);
        chk("R2 hiz in predelay despite ref", pwm_hiz, 1);
        ref_at_vout = 1'b0;
        ticks(1);
        chk("R2 dac zero after 64th tick", dac_code, 0);
        ticks(5);
        chk("R3 dac after 5 ramp ticks", dac_code, 5);
        chk("R4 hiz before ref catch-up", pwm_hiz, 1);
        clocks(4);
        chk("R3 no step without tick", dac_code, 5);
        ref_at_vout = 1'b1;
        clocks(1);
        chk("R4 PWM released after ref", pwm_hiz, 0);
        chk("R5 no pgood during ramp", pgood, 0);
        ticks(15);
        chk("R3 dac reaches target", dac_code, 20);
        ticks(3);
        chk("R3 dac holds at target", dac_code, 20);
        chk("R5 pgood in window", pgood, 1);
        vout_in_window = 1'b0;
        #1;
        chk("R5 pgood drops out of window", pgood, 0);
        vout_in_window = 1'b1;
        #1;
        chk("R5 pgood returns", pgood, 1);
    endtask

    task automatic t_noload;
        vid_code = 6'h3F;
        ticks(1);
        chk("R6 hiz unchanged after 1 tick", pwm_hiz, 0);
        chk("R6 level unchanged after 1 tick", ov_shutdown_lvl, 0);
        chk("R6 dac unchanged after 1 tick", dac_code, 20);
        ticks(1);
        chk("R6 hiz after 2 ticks", pwm_hiz, 1);
        chk("R6 level after 2 ticks", ov_shutdown_lvl, 1);
        chk("R6 dac cleared", dac_code, 0);
        chk("R6 pgood cleared", pgood, 0);
        vid_code = 6'h11;
        clocks(1);
        chk("R7 restart level", ov_shutdown_lvl, 0);
        chk("R7 restart hiz", pwm_hiz, 1);
        ticks(64 + 4);
        chk("R7 ramp after restart", dac_code, 4);
        vid_code = 6'h3E;
        ticks(2);
        chk("R6 3E shuts down", ov_shutdown_lvl, 1);
        vid_code = 6'h10;
        clocks(1);
        chk("R7 restart after 3E", ov_shutdown_lvl, 0);
        por_ok = 1'b0;
        clocks(2);
    endtask

    task automatic t_disable;
        go_regulate(10);
        chk("R3 quick start target", dac_code, 10);
        en_logic = 1'b0;
        clocks(1);
        chk("R9 dac cleared", dac_code, 0);
        chk("R9 pgood cleared", pgood, 0);
        chk("R9 hiz", pwm_hiz, 1);
        en_logic = 1'b1;
        go_regulate(6);
        en_cmp = 1'b0;
        clocks(1);
        chk("R9 en_cmp drop clears dac", dac_code, 0);
        por_ok = 1'b0;
        clocks(2);
    endtask

    task automatic t_ov_latch;
        go_regulate(7);
        chk("R5 pgood before fault", pgood, 1);
        ov_fault = 1'b1;
        clocks(1);
        ov_fault = 1'b0;
        chk("R8 hiz after fault", pwm_hiz, 1);
        chk("R8 level after fault", ov_shutdown_lvl, 1);
        vid_code = 6'h3F;
        ticks(3);
        vid_code = 6'h10;
        ticks(3);
        chk("R8 noload codes do not clear", ov_shutdown_lvl, 1);
        en_cmp = 1'b0;
        clocks(2);
        en_cmp = 1'b1;
        clocks(2);
        chk("R8 enable toggle does not clear", ov_shutdown_lvl, 1);
        chk("R8 still hiz", pwm_hiz, 1);
        por_ok = 1'b0;
        clocks(1);
        por_ok = 1'b1;
        clocks(1);
        chk("R8 por drop clears latch", ov_shutdown_lvl, 0);
        por_ok = 1'b0;
        clocks(2);
    endtask

    initial begin
        clocks(3);
        t_reset();
        rst_n = 1'b1;
        clocks(2);
        t_reset();
        t_start_blocked();
        t_normal_start();
        t_noload();
        t_disable();
        t_ov_latch();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule